// File: doc/BRIEF.md
# Multichannel Sensor Scan Sequencer

This block is a synchronous controller that polls four pulse-output sensors one after another. A free-running 4-bit cycle counter is compared against fixed codes to produce four registered single-cycle control strobes: a counter clear for the downstream pulse counter, a count-window marker, a shift-register start and a shift-register clear. For the first ten clocks after reset no strobe is issued. After that, the strobes repeat every 16 clocks.

A 2-bit channel index steps forward on each counter-clear strobe. The index drives a one-hot sensor enable and the select of a 4:1 multiplexer over the sensor pulse lines. The sensor pulse inputs are asynchronous. Each one passes through a two-flop synchronizer and a rising-edge detector. Only edges of the selected sensor reach the gated pulse output, and only during a three-clock window that opens right after the window marker. The sensors and the downstream counter are outside this block.

Top module: `sensor_scan_seq`

## Requirements
- R1: While `rst` is high at a clock edge, all strobes, `en_o`, `ch_o` and `pulse_o` are 0 after that edge.
- R2: No strobe is high during the first 10 clock cycles after the first edge with `rst` low.
- R3: Let k be the number of edges with `rst` low since reset, and let p = (k-1) mod 16. Once k ≥ 11, the strobe outputs after edge k are set as follows: `clr_cnt_o` when p = 6 (binary 0110), `win_mark_o` when p = 9 (1001), `shift_go_o` when p = 5 (0101) and `shift_clr_o` when p = 10 (1010).
- R4: Each strobe is one clock wide and repeats every 16 clocks. At most one strobe is high in any cycle.
- R5: `ch_o` increases by one, wrapping from 3 to 0, in the cycle after each `clr_cnt_o` pulse. At all other times it holds its value.
- R6: `en_o` is either zero or has exactly bit i set, where i = `ch_o`. It is nonzero from the cycle after a `win_mark_o` pulse up to and including the cycle of the next `clr_cnt_o` pulse.
- R7: Rising edges on any sensor input other than `sens_i[ch_o]` never appear on `pulse_o`.
- R8: `pulse_o` can be high only in the three cycles that follow a `win_mark_o` pulse.
- R9: A rising edge on the selected sensor, driven between edges E-1 and E, shows on `pulse_o` as a single high cycle after edge E+1. This holds however long the input stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sens_i | input | 4 | Asynchronous sensor pulse lines |
| clr_cnt_o | output | 1 | Counter clear strobe |
| win_mark_o | output | 1 | Count-window marker strobe |
| shift_go_o | output | 1 | Shift-register start strobe |
| shift_clr_o | output | 1 | Shift-register clear strobe |
| en_o | output | 4 | One-hot sensor enable |
| ch_o | output | 2 | Active channel index |
| pulse_o | output | 1 | Gated single-cycle pulse stream |

## Verification
The hardest case to reach from the ports is a sensor edge that arrives at the very edge of the three-cycle window. The two-clock synchronizer delay decides whether such an edge is counted. The bench waits for the window marker, then drives the selected sensor zero, one or two cycles later. It expects the first two cases to count and the third to miss the window. Further vectors drive the next channel instead of the selected one, and hold a line high across the whole window to show that it counts only once.

// File: rtl/sensor_scan_seq.sv
module sensor_scan_seq #(
  parameter int N_CH      = 4,
  parameter int CNT_W     = 4,
  parameter int SETUP_CYC = 10,
  parameter int WIN_LEN   = 3,
  parameter logic [CNT_W-1:0] CODE_CLR   = 4'd6,
  parameter logic [CNT_W-1:0] CODE_WIN   = 4'd9,
  parameter logic [CNT_W-1:0] CODE_SHIFT = 4'd5,
  parameter logic [CNT_W-1:0] CODE_SCLR  = 4'd10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_CH-1:0] sens_i,
  output logic            clr_cnt_o,
  output logic            win_mark_o,
  output logic            shift_go_o,
  output logic            shift_clr_o,
  output logic [N_CH-1:0] en_o,
  output logic [((N_CH > 1) ? $clog2(N_CH) : 1)-1:0] ch_o,
  output logic            pulse_o
);
  localparam int CH_W   = (N_CH > 1) ? $clog2(N_CH) : 1;
  localparam int HOLD_W = $clog2(SETUP_CYC + 1);
  localparam int WIN_W  = $clog2(WIN_LEN + 1);

  logic [CNT_W-1:0]  phase;
  logic [HOLD_W-1:0] hold;
  logic              armed;
  logic              live;
  logic [WIN_W-1:0]  win;
  logic [N_CH-1:0]   s1, s2, s3, rise;

  assign armed = (hold == HOLD_W'(SETUP_CYC));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      hold  <= '0;
    end else begin
      phase <= phase + 1'b1;
      if (!armed) hold <= hold + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clr_cnt_o   <= 1'b0;
      win_mark_o  <= 1'b0;
      shift_go_o  <= 1'b0;
      shift_clr_o <= 1'b0;
    end else begin
      clr_cnt_o   <= armed && (phase == CODE_CLR);
      win_mark_o  <= armed && (phase == CODE_WIN);
      shift_go_o  <= armed && (phase == CODE_SHIFT);
      shift_clr_o <= armed && (phase == CODE_SCLR);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_o <= '0;
      live <= 1'b0;
      win  <= '0;
    end else begin
      if (clr_cnt_o) ch_o <= ch_o + 1'b1;
      if (win_mark_o) live <= 1'b1;
      else if (clr_cnt_o) live <= 1'b0;
      if (win_mark_o) win <= WIN_W'(WIN_LEN);
      else if (win != '0) win <= win - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= sens_i;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise = s2 & ~s3;

  for (genvar i = 0; i < N_CH; i++) begin : g_en
    assign en_o[i] = live && (ch_o == CH_W'(i));
  end

  assign pulse_o = (win != '0) && rise[ch_o];

  a_r2_holdoff: assert property (@(posedge clk) disable iff (rst)
    !armed |=> !(clr_cnt_o || win_mark_o || shift_go_o || shift_clr_o));
  a_r4_one_wide: assert property (@(posedge clk) disable iff (rst)
    (clr_cnt_o || win_mark_o || shift_go_o || shift_clr_o) |=>
      !($past(clr_cnt_o) && clr_cnt_o) && !($past(win_mark_o) && win_mark_o));
  a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
    $countones({clr_cnt_o, win_mark_o, shift_go_o, shift_clr_o}) <= 1);
  a_r5_ch_step: assert property (@(posedge clk) disable iff (rst)
    clr_cnt_o |=> ch_o == $past(ch_o) + 1'b1);
  a_r5_ch_hold: assert property (@(posedge clk) disable iff (rst)
    !clr_cnt_o |=> $stable(ch_o));
  a_r6_en_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(en_o));
  a_r6_en_off: assert property (@(posedge clk) disable iff (rst)
    clr_cnt_o |=> en_o == '0);
  a_r8_window_open: assert property (@(posedge clk) disable iff (rst)
    win_mark_o |=> win == WIN_W'(WIN_LEN));
endmodule

// File: tb/test_sensor_scan_seq.sv
module test_sensor_scan_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] sens_i = '0;
  logic       clr_cnt_o, win_mark_o, shift_go_o, shift_clr_o, pulse_o;
  logic [3:0] en_o;
  logic [1:0] ch_o;

  int checks = 0;
  int fails  = 0;
  int k = 0;
  int pcount = 0;
  int m_ch = 0;
  bit m_live = 0, p_clr = 0, p_sys = 0;

  sensor_scan_seq i_sensor_scan_seq (
    .clk(clk), .rst(rst), .sens_i(sens_i),
    .clr_cnt_o(clr_cnt_o), .win_mark_o(win_mark_o), .shift_go_o(shift_go_o),
    .shift_clr_o(shift_clr_o), .en_o(en_o), .ch_o(ch_o), .pulse_o(pulse_o)
  );

  always #10 clk = ~clk;

  always @(posedge clk) k <= rst ? 0 : k + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at k=%0d", req, act, exp, k);
    end
  endtask

  always @(negedge clk) begin
    if (k == 0) begin
      m_ch = 0; m_live = 0; p_clr = 0; p_sys = 0;
      chk("R1 outputs", {clr_cnt_o, win_mark_o, shift_go_o, shift_clr_o, en_o, ch_o, pulse_o}, 0);
    end else begin
      int p;
      bit armed;
      logic [3:0] es;
      if (p_clr) m_ch = (m_ch + 1) % 4;
      if (p_sys) m_live = 1; else if (p_clr) m_live = 0;
      p = (k - 1) % 16;
      armed = (k >= 11);
      es = {armed && p == 6, armed && p == 9, armed && p == 5, armed && p == 10};
      if (k <= 10) chk("R2 holdoff", {clr_cnt_o, win_mark_o, shift_go_o, shift_clr_o}, 0);
      else chk("R3 R4 strobes", {clr_cnt_o, win_mark_o, shift_go_o, shift_clr_o}, es);
      chk("R5 channel", ch_o, m_ch);
      chk("R6 enable", en_o, m_live ? (1 << m_ch) : 0);
      p_clr = es[3];
      p_sys = es[2];
      if (pulse_o) pcount++;
    end
  end

  typedef struct packed { int off; int dly; int held; int exp; } vec_t;
  localparam vec_t VECS [6] = '{
    '{0, 0, 1, 1},
    '{0, 1, 2, 1},
    '{0, 2, 1, 0},
    '{1, 0, 1, 0},
    '{0, 0, 6, 1},
    '{3, 1, 1, 0}
  };

  task automatic run_vec(input vec_t v, input string req);
    int tgt;
    forever begin
      @(negedge clk);
      if (win_mark_o) break;
    end
    #1;
    tgt = (m_ch + v.off) % 4;
    pcount = 0;
    repeat (v.dly) @(negedge clk);
    sens_i[tgt] = 1'b1;
    repeat (v.held) @(negedge clk);
    sens_i[tgt] = 1'b0;
    repeat (10) @(negedge clk);
    chk(req, pcount, v.exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (40) @(negedge clk);
    for (int i = 0; i < 6; i++)
      run_vec(VECS[i], "R7 R8 R9 gated pulse");
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (60) @(negedge clk);
    run_vec('{0, 1, 1, 1}, "R9 after reset");
    run_vec('{2, 0, 3, 0}, "R7 after reset");
    repeat (20) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule